// File: doc/BRIEF.md
# Dual-Issue Dependency Stall Calculator

This block sits beside the issue stage of an in-order pipeline that can launch two instructions per cycle. It looks at the older and the younger instruction of a fetched pair and works out how many cycles the younger one has to wait. Each instruction arrives already decoded. The block receives its group class, an operation kind, its register operands (each a valid bit, a floating-point flag and an index) and, for the older instruction, two latency figures.

Three kinds of conflict are evaluated in parallel:

- read-after-write, where the younger instruction reads a result of the older one;
- write-after-write, where both instructions write the same register;
- write-after-read, where the younger instruction overwrites something the older one still reads.

Each kind has its own pair-specific stall rule. The largest of the three stall counts is reported, together with a code that names the winning conflict.

When the issue stage presents a pair and no hold is active, a registered down-counter captures the stall. It raises `hold` until the wait has elapsed, so the issue logic only has to watch one signal.

Top module: `dual_issue_stall_unit`

## Requirements
- R1: A read-after-write exists when a valid younger source equals a valid older destination in both index and floating-point flag. Its stall equals `old_lat`, unless R5, R6 or R7 adjust it. A matching index with a differing flag is not a conflict.
- R2: A write-after-write is counted only when `old_grp`=1 (FE), `yng_grp`=0 (LS), and the valid younger destination matches either valid older destination. It uses `old_lat_last`, which is the latency to the final write-back of the older instruction.
- R3: The write-after-write stall is `old_lat_last`-1 when `old_kind`=2 (divide or square root). For any other older kind it is `old_lat_last`-2. Both results saturate at 0.
- R4: A write-after-read exists when the valid younger destination matches a valid older source. It stalls 5 cycles when `old_kind`=4 (vector transform), 2 cycles when `old_kind`=3 (double add, subtract or multiply), and 0 for every other older kind.
- R5: When the older kind is an FP computation (kinds 1 to 5) and `yng_kind`=7 (FP store), the read-after-write latency is lowered by one. The result saturates at 0.
- R6: When `old_kind`=6 (load) and `yng_kind`=8 (dynamic shift), and the match is on younger source slot 1 (the shift amount), the read-after-write latency is raised by one.
- R7: An older instruction with at least one valid FP destination and `old_lat` below 2 is treated as latency 2 when `yng_kind` is 3 or 9 (double precision), 5 (inner product) or 4 (vector transform).
- R8: `stall_cycles` is the maximum of the three conflict stalls. `hazard` names the conflict that produced it: 0 none, 1 RAW, 2 WAW, 3 WAR. On a tie the priority is RAW, then WAW, then WAR. `hazard` is 0 whenever `stall_cycles` is 0.
- R9: When `issue_valid` is high and `remain` is 0, `remain` loads `stall_cycles` on the next clock edge. While `remain` is nonzero it decreases by one per cycle, and `hold` is high.
- R10: `issue_valid` has no effect while `hold` is high. A synchronous `rst` sets `remain` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | A pair is presented for issue |
| old_grp | input | 1 | Older group class: 1 FE, 0 LS |
| old_kind | input | 4 | Older operation kind |
| old_lat | input | LW | Older base latency |
| old_lat_last | input | LW | Older latency to final write-back |
| old_dst_vld | input | 2 | Older destination valid bits |
| old_dst_fp | input | 2 | Older destination FP flags |
| old_dst_idx | input | 2*RW | Older destination indices, slot 0 in the low bits |
| old_src_vld | input | 2 | Older source valid bits |
| old_src_fp | input | 2 | Older source FP flags |
| old_src_idx | input | 2*RW | Older source indices |
| yng_grp | input | 1 | Younger group class |
| yng_kind | input | 4 | Younger operation kind |
| yng_src_vld | input | 2 | Younger source valid bits (slot 1 holds the shift amount) |
| yng_src_fp | input | 2 | Younger source FP flags |
| yng_src_idx | input | 2*RW | Younger source indices |
| yng_dst_vld | input | 1 | Younger destination valid |
| yng_dst_fp | input | 1 | Younger destination FP flag |
| yng_dst_idx | input | RW | Younger destination index |
| stall_cycles | output | LW+1 | Computed stall for the current pair |
| hazard | output | 2 | Conflict that set the stall |
| hold | output | 1 | Younger instruction held |
| remain | output | LW+1 | Countdown of remaining hold cycles |

## Verification
The bench targets the places where arithmetic or matching is easy to get wrong.

- Saturation of the minus-one and minus-two adjustments at small latencies. A design without it would wrap to a huge stall.
- The FP flag in register matching. Ignoring it would stall integer and FP pairs that share an index.
- The group gate on write-after-write. Without it, any pair sharing a destination would stall.
- The shift-amount slot in the load-to-shift rule.
- The latency-two floor ahead of double-precision, inner product and vector transform consumers.
- Tie-breaking between simultaneous conflicts, which a wrong arbiter would report under the wrong code.
- The countdown ignoring new pairs while holding. Getting this wrong would reload and stretch the hold.

// File: rtl/stall_pkg.sv
package stall_pkg;

  typedef enum logic [3:0] {
    K_OTHER     = 4'd0,
    K_FPCALC    = 4'd1,
    K_FDIVSQRT  = 4'd2,
    K_FDBLARITH = 4'd3,
    K_FXFORM    = 4'd4,
    K_FINNER    = 4'd5,
    K_LOAD      = 4'd6,
    K_FSTORE    = 4'd7,
    K_DSHIFT    = 4'd8,
    K_FDBLOTHER = 4'd9
  } op_kind_e;

  typedef enum logic [1:0] {
    HZ_NONE = 2'd0,
    HZ_RAW  = 2'd1,
    HZ_WAW  = 2'd2,
    HZ_WAR  = 2'd3
  } hazard_e;

  localparam logic GRP_LS = 1'b0;
  localparam logic GRP_FE = 1'b1;

  function automatic logic is_fp_compute(op_kind_e k);
    return (k == K_FPCALC) || (k == K_FDIVSQRT) || (k == K_FDBLARITH) ||
           (k == K_FXFORM) || (k == K_FINNER);
  endfunction

  function automatic logic needs_lat_floor(op_kind_e k);
    return (k == K_FDBLARITH) || (k == K_FDBLOTHER) ||
           (k == K_FINNER) || (k == K_FXFORM);
  endfunction

endpackage

// File: rtl/stall_hazard_detect.sv
module stall_hazard_detect #(
  parameter int RW   = 5,
  parameter int NOPS = 2
) (
  input  logic [NOPS-1:0]    od_vld,
  input  logic [NOPS-1:0]    od_fp,
  input  logic [NOPS*RW-1:0] od_idx,
  input  logic [NOPS-1:0]    os_vld,
  input  logic [NOPS-1:0]    os_fp,
  input  logic [NOPS*RW-1:0] os_idx,
  input  logic [NOPS-1:0]    ys_vld,
  input  logic [NOPS-1:0]    ys_fp,
  input  logic [NOPS*RW-1:0] ys_idx,
  input  logic               yd_vld,
  input  logic               yd_fp,
  input  logic [RW-1:0]      yd_idx,
  output logic               raw_hit,
  output logic               raw_shamt_hit,
  output logic               war_hit,
  output logic               waw_match,
  output logic               old_fp_write
);
  localparam int SHAMT_SLOT = 1;

  logic [NOPS-1:0] src_hit;
  logic [NOPS-1:0] war_slot;
  logic [NOPS-1:0] waw_slot;

  for (genvar j = 0; j < NOPS; j++) begin : g_ysrc
    logic [NOPS-1:0] per_dst;
    for (genvar i = 0; i < NOPS; i++) begin : g_odst
      assign per_dst[i] = od_vld[i] && ys_vld[j] && (od_fp[i] == ys_fp[j]) &&
                          (od_idx[i*RW +: RW] == ys_idx[j*RW +: RW]);
    end
    assign src_hit[j] = |per_dst;
  end

  for (genvar i = 0; i < NOPS; i++) begin : g_slot
    assign war_slot[i] = yd_vld && os_vld[i] && (os_fp[i] == yd_fp) &&
                         (os_idx[i*RW +: RW] == yd_idx);
    assign waw_slot[i] = yd_vld && od_vld[i] && (od_fp[i] == yd_fp) &&
                         (od_idx[i*RW +: RW] == yd_idx);
  end

  assign raw_hit       = |src_hit;
  assign raw_shamt_hit = src_hit[SHAMT_SLOT];
  assign war_hit       = |war_slot;
  assign waw_match     = |waw_slot;
  assign old_fp_write  = |(od_vld & od_fp);
endmodule

// File: rtl/stall_rule_calc.sv
module stall_rule_calc
  import stall_pkg::*;
#(
  parameter int LW = 4,
  parameter int CW = LW + 1
) (
  input  op_kind_e        old_kind,
  input  op_kind_e        yng_kind,
  input  logic            old_grp,
  input  logic            yng_grp,
  input  logic [LW-1:0]   old_lat,
  input  logic [LW-1:0]   old_lat_last,
  input  logic            raw_hit,
  input  logic            raw_shamt_hit,
  input  logic            war_hit,
  input  logic            waw_match,
  input  logic            old_fp_write,
  output logic            raw_act,
  output logic            waw_act,
  output logic            war_act,
  output logic [CW-1:0]   raw_cnt,
  output logic [CW-1:0]   waw_cnt,
  output logic [CW-1:0]   war_cnt
);
  localparam logic [CW-1:0] WAR_XFORM = CW'(5);
  localparam logic [CW-1:0] WAR_DBL   = CW'(2);
  localparam logic [CW-1:0] LAT_FLOOR = CW'(2);

  function automatic logic [CW-1:0] sat_dec(logic [CW-1:0] v, logic [CW-1:0] amt);
    return (v > amt) ? (v - amt) : '0;
  endfunction

  function automatic logic [CW-1:0] raw_latency(logic [LW-1:0] lat, op_kind_e ok,
                                                op_kind_e yk, logic fpw, logic shamt);
    logic [CW-1:0] e;
    e = CW'(lat);
    if (fpw && (e < LAT_FLOOR) && needs_lat_floor(yk)) e = LAT_FLOOR;
    if (is_fp_compute(ok) && (yk == K_FSTORE))          e = sat_dec(e, CW'(1));
    if ((ok == K_LOAD) && (yk == K_DSHIFT) && shamt)    e = e + CW'(1);
    return e;
  endfunction

  function automatic logic [CW-1:0] waw_latency(logic [LW-1:0] lat_last, op_kind_e ok);
    return sat_dec(CW'(lat_last), (ok == K_FDIVSQRT) ? CW'(1) : CW'(2));
  endfunction

  function automatic logic [CW-1:0] war_latency(op_kind_e ok);
    case (ok)
      K_FXFORM:    return WAR_XFORM;
      K_FDBLARITH: return WAR_DBL;
      default:     return '0;
    endcase
  endfunction

  assign raw_act = raw_hit;
  assign raw_cnt = raw_latency(old_lat, old_kind, yng_kind, old_fp_write, raw_shamt_hit);
  assign waw_act = waw_match && (old_grp == GRP_FE) && (yng_grp == GRP_LS);
  assign waw_cnt = waw_latency(old_lat_last, old_kind);
  assign war_cnt = war_latency(old_kind);
  assign war_act = war_hit && (war_cnt != '0);
endmodule

// File: rtl/stall_arbiter.sv
module stall_arbiter
  import stall_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          raw_act,
  input  logic          waw_act,
  input  logic          war_act,
  input  logic [CW-1:0] raw_cnt,
  input  logic [CW-1:0] waw_cnt,
  input  logic [CW-1:0] war_cnt,
  output logic [CW-1:0] stall,
  output hazard_e       kind
);
  logic [CW-1:0] raw_v, waw_v, war_v;

  assign raw_v = raw_act ? raw_cnt : '0;
  assign waw_v = waw_act ? waw_cnt : '0;
  assign war_v = war_act ? war_cnt : '0;

  always_comb begin
    stall = raw_v;
    kind  = HZ_RAW;
    if (waw_v > stall) begin
      stall = waw_v;
      kind  = HZ_WAW;
    end
    if (war_v > stall) begin
      stall = war_v;
      kind  = HZ_WAR;
    end
    if (stall == '0) kind = HZ_NONE;
  end
endmodule

// File: rtl/stall_countdown.sv
module stall_countdown #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_valid,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] remain,
  output logic          hold
);
  logic [CW-1:0] cnt_q;
  logic          take;

  assign hold = (cnt_q != '0);
  assign take = issue_valid && !hold;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (take)  cnt_q <= load_val;
    else if (hold)  cnt_q <= cnt_q - CW'(1);
  end

  assign remain = cnt_q;
endmodule

// File: rtl/dual_issue_stall_unit.sv
module dual_issue_stall_unit
  import stall_pkg::*;
#(
  parameter int LW   = 4,
  parameter int RW   = 5,
  parameter int NOPS = 2,
  localparam int CW  = LW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_valid,
  input  logic               old_grp,
  input  logic [3:0]         old_kind,
  input  logic [LW-1:0]      old_lat,
  input  logic [LW-1:0]      old_lat_last,
  input  logic [NOPS-1:0]    old_dst_vld,
  input  logic [NOPS-1:0]    old_dst_fp,
  input  logic [NOPS*RW-1:0] old_dst_idx,
  input  logic [NOPS-1:0]    old_src_vld,
  input  logic [NOPS-1:0]    old_src_fp,
  input  logic [NOPS*RW-1:0] old_src_idx,
  input  logic               yng_grp,
  input  logic [3:0]         yng_kind,
  input  logic [NOPS-1:0]    yng_src_vld,
  input  logic [NOPS-1:0]    yng_src_fp,
  input  logic [NOPS*RW-1:0] yng_src_idx,
  input  logic               yng_dst_vld,
  input  logic               yng_dst_fp,
  input  logic [RW-1:0]      yng_dst_idx,
  output logic [CW-1:0]      stall_cycles,
  output logic [1:0]         hazard,
  output logic               hold,
  output logic [CW-1:0]      remain
);
  op_kind_e      okind, ykind;
  hazard_e       hz;
  logic          raw_hit, raw_shamt_hit, war_hit, waw_match, old_fp_write;
  logic          raw_act, waw_act, war_act;
  logic [CW-1:0] raw_cnt, waw_cnt, war_cnt;

  assign okind = op_kind_e'(old_kind);
  assign ykind = op_kind_e'(yng_kind);

  stall_hazard_detect #(.RW(RW), .NOPS(NOPS)) u_detect (
    .od_vld(old_dst_vld), .od_fp(old_dst_fp), .od_idx(old_dst_idx),
    .os_vld(old_src_vld), .os_fp(old_src_fp), .os_idx(old_src_idx),
    .ys_vld(yng_src_vld), .ys_fp(yng_src_fp), .ys_idx(yng_src_idx),
    .yd_vld(yng_dst_vld), .yd_fp(yng_dst_fp), .yd_idx(yng_dst_idx),
    .raw_hit(raw_hit), .raw_shamt_hit(raw_shamt_hit), .war_hit(war_hit),
    .waw_match(waw_match), .old_fp_write(old_fp_write)
  );

  stall_rule_calc #(.LW(LW), .CW(CW)) u_rules (
    .old_kind(okind), .yng_kind(ykind), .old_grp(old_grp), .yng_grp(yng_grp),
    .old_lat(old_lat), .old_lat_last(old_lat_last),
    .raw_hit(raw_hit), .raw_shamt_hit(raw_shamt_hit), .war_hit(war_hit),
    .waw_match(waw_match), .old_fp_write(old_fp_write),
    .raw_act(raw_act), .waw_act(waw_act), .war_act(war_act),
    .raw_cnt(raw_cnt), .waw_cnt(waw_cnt), .war_cnt(war_cnt)
  );

  stall_arbiter #(.CW(CW)) u_arb (
    .raw_act(raw_act), .waw_act(waw_act), .war_act(war_act),
    .raw_cnt(raw_cnt), .waw_cnt(waw_cnt), .war_cnt(war_cnt),
    .stall(stall_cycles), .kind(hz)
  );

  assign hazard = hz;

  stall_countdown #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .issue_valid(issue_valid),
    .load_val(stall_cycles), .remain(remain), .hold(hold)
  );
endmodule

// File: rtl/stall_checker.sv
module stall_checker #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_valid,
  input logic          old_grp,
  input logic          yng_grp,
  input logic [3:0]    old_kind,
  input logic [CW-1:0] stall_cycles,
  input logic [1:0]    hazard,
  input logic          hold,
  input logic [CW-1:0] remain,
  input logic          raw_act,
  input logic          waw_act,
  input logic          war_act,
  input logic [CW-1:0] raw_cnt,
  input logic [CW-1:0] waw_cnt,
  input logic [CW-1:0] war_cnt
);
  a_r9_decrement: assert property (@(posedge clk) disable iff (rst)
    (remain != '0) |=> (remain == ($past(remain) - CW'(1))));

  a_r9_load: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !hold) |=> (remain == $past(stall_cycles)));

  a_r10_hold_level: assert property (@(posedge clk) disable iff (rst)
    hold |-> (remain != '0));

  a_r8_none_zero: assert property (@(posedge clk) disable iff (rst)
    (hazard == 2'd0) |-> (stall_cycles == '0));

  a_r8_max_raw: assert property (@(posedge clk) disable iff (rst)
    raw_act |-> (stall_cycles >= raw_cnt));

  a_r8_max_waw: assert property (@(posedge clk) disable iff (rst)
    waw_act |-> (stall_cycles >= waw_cnt));

  a_r8_max_war: assert property (@(posedge clk) disable iff (rst)
    war_act |-> (stall_cycles >= war_cnt));

  a_r2_waw_groups: assert property (@(posedge clk) disable iff (rst)
    (hazard == 2'd2) |-> (old_grp && !yng_grp));

  a_r4_war_values: assert property (@(posedge clk) disable iff (rst)
    (hazard == 2'd3) |-> ((stall_cycles == CW'(5) && old_kind == 4'd4) ||
                          (stall_cycles == CW'(2) && old_kind == 4'd3)));
endmodule

bind dual_issue_stall_unit stall_checker #(.CW(CW)) u_stall_checker (
  .clk(clk), .rst(rst), .issue_valid(issue_valid),
  .old_grp(old_grp), .yng_grp(yng_grp), .old_kind(old_kind),
  .stall_cycles(stall_cycles), .hazard(hazard), .hold(hold), .remain(remain),
  .raw_act(raw_act), .waw_act(waw_act), .war_act(war_act),
  .raw_cnt(raw_cnt), .waw_cnt(waw_cnt), .war_cnt(war_cnt)
);

// File: tb/dual_issue_stall_unit_bench.sv
`timescale 1ns/100ps
module dual_issue_stall_unit_bench;
  localparam int LW = 4;
  localparam int RW = 5;
  localparam int CW = LW + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, issue_valid, o_grp, y_grp;
  logic [3:0]    o_kind, y_kind;
  logic [LW-1:0] o_lat, o_latl;
  logic          od_v[2], od_f[2], os_v[2], os_f[2], ys_v[2], ys_f[2];
  logic [RW-1:0] od_i[2], os_i[2], ys_i[2];
  logic          yd_v, yd_f;
  logic [RW-1:0] yd_i;

  logic [CW-1:0] stall_cycles, remain;
  logic [1:0]    hazard;
  logic          hold;

  dual_issue_stall_unit #(.LW(LW), .RW(RW)) u_dual_issue_stall_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid),
    .old_grp(o_grp), .old_kind(o_kind), .old_lat(o_lat), .old_lat_last(o_latl),
    .old_dst_vld({od_v[1], od_v[0]}), .old_dst_fp({od_f[1], od_f[0]}),
    .old_dst_idx({od_i[1], od_i[0]}),
    .old_src_vld({os_v[1], os_v[0]}), .old_src_fp({os_f[1], os_f[0]}),
    .old_src_idx({os_i[1], os_i[0]}),
    .yng_grp(y_grp), .yng_kind(y_kind),
    .yng_src_vld({ys_v[1], ys_v[0]}), .yng_src_fp({ys_f[1], ys_f[0]}),
    .yng_src_idx({ys_i[1], ys_i[0]}),
    .yng_dst_vld(yd_v), .yng_dst_fp(yd_f), .yng_dst_idx(yd_i),
    .stall_cycles(stall_cycles), .hazard(hazard), .hold(hold), .remain(remain)
  );

  int checks = 0;
  int fails  = 0;
  int model_cnt = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: candidate list, first maximum wins.
  task automatic ref_pair(output int st, output int hz);
    int cand[$];
    bit raw = 0, shamt = 0, war = 0, waw = 0, fpw = 0;
    int r, w, a;
    for (int d = 0; d < 2; d++) begin
      if (od_v[d] && od_f[d]) fpw = 1;
      for (int s = 0; s < 2; s++)
        if (od_v[d] && ys_v[s] && od_f[d] == ys_f[s] && od_i[d] == ys_i[s]) begin
          raw = 1;
          if (s == 1) shamt = 1;
        end
      if (yd_v && od_v[d] && od_f[d] == yd_f && od_i[d] == yd_i) waw = 1;
      if (yd_v && os_v[d] && os_f[d] == yd_f && os_i[d] == yd_i) war = 1;
    end
    r = int'(o_lat);
    if (fpw && r < 2 && (y_kind == 3 || y_kind == 9 || y_kind == 5 || y_kind == 4)) r = 2;
    if (o_kind >= 1 && o_kind <= 5 && y_kind == 7) r = (r > 0) ? r - 1 : 0;
    if (o_kind == 6 && y_kind == 8 && shamt) r = r + 1;
    w = int'(o_latl) - ((o_kind == 2) ? 1 : 2);
    if (w < 0) w = 0;
    a = (o_kind == 4) ? 5 : (o_kind == 3) ? 2 : 0;
    cand.push_back(raw ? r : 0);
    cand.push_back((waw && o_grp && !y_grp) ? w : 0);
    cand.push_back(war ? a : 0);
    st = 0; hz = 0;
    foreach (cand[k]) if (cand[k] > st) begin st = cand[k]; hz = k + 1; end
  endtask

  // Compare on the falling edge, then advance the model across the rising edge.
  task automatic step();
    int st, hz;
    @(negedge clk);
    ref_pair(st, hz);
    chk(int'(stall_cycles) == st, (hz == 1) ? "R1 stall" : (hz == 2) ? "R2 stall" :
        (hz == 3) ? "R4 stall" : "R8 stall", int'(stall_cycles), st);
    chk(int'(hazard) == hz, "R8 hazard", int'(hazard), hz);
    chk(int'(remain) == model_cnt, "R9 remain", int'(remain), model_cnt);
    chk(hold == (model_cnt != 0), "R9 hold", int'(hold), int'(model_cnt != 0));
    if (rst) model_cnt = 0;
    else if (issue_valid && model_cnt == 0) model_cnt = st;
    else if (model_cnt > 0) model_cnt--;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_stall(int exp, string tag);
    @(negedge clk);
    chk(int'(stall_cycles) == exp, tag, int'(stall_cycles), exp);
  endtask

  task automatic clear_pair();
    issue_valid = 0; o_grp = 1; y_grp = 1; o_kind = 0; y_kind = 0;
    o_lat = 0; o_latl = 0; yd_v = 0; yd_f = 0; yd_i = 0;
    for (int k = 0; k < 2; k++) begin
      od_v[k] = 0; od_f[k] = 0; od_i[k] = 0;
      os_v[k] = 0; os_f[k] = 0; os_i[k] = 0;
      ys_v[k] = 0; ys_f[k] = 0; ys_i[k] = 0;
    end
  endtask

  task automatic raw_link(int dslot, int sslot, bit fp, int idx);
    od_v[dslot] = 1; od_f[dslot] = fp; od_i[dslot] = RW'(idx);
    ys_v[sslot] = 1; ys_f[sslot] = fp; ys_i[sslot] = RW'(idx);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_pair();
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    step();
    rst = 0;
    // R10: the counter is clear out of reset
    @(negedge clk);
    chk(remain == 0 && hold == 0, "R10 reset", int'(remain), 0);

    // R1: integer flow dependency
    clear_pair(); o_lat = 3; raw_link(0, 0, 0, 4);
    expect_stall(3, "R1"); step();
    // R1: same index, different FP flag
    ys_f[0] = 1; expect_stall(0, "R1 flag"); step();
    // R2: FE then LS on the same destination, second dest slot
    clear_pair(); o_grp = 1; y_grp = 0; o_latl = 6; od_v[1] = 1; od_i[1] = 9;
    yd_v = 1; yd_i = 9; expect_stall(4, "R2"); step();
    // R2: wrong group order yields nothing
    o_grp = 0; y_grp = 1; expect_stall(0, "R2 groups"); step();
    // R3: divide/sqrt takes minus one, others saturate
    o_grp = 1; y_grp = 0; o_kind = 2; o_latl = 10; expect_stall(9, "R3 div"); step();
    o_kind = 1; o_latl = 1; expect_stall(0, "R3 saturate"); step();
    // R4: write-after-read rules
    clear_pair(); os_v[0] = 1; os_i[0] = 7; yd_v = 1; yd_i = 7;
    o_kind = 4; expect_stall(5, "R4 xform"); step();
    o_kind = 3; expect_stall(2, "R4 dbl"); step();
    o_kind = 1; expect_stall(0, "R4 other"); step();
    // R5: FP computation feeding an FP store
    clear_pair(); o_kind = 1; y_kind = 7; o_lat = 3; raw_link(0, 0, 1, 2);
    expect_stall(2, "R5"); step();
    o_lat = 0; expect_stall(0, "R5 saturate"); step();
    // R6: load supplying a shift amount
    clear_pair(); o_kind = 6; y_kind = 8; o_lat = 2; raw_link(0, 1, 0, 3);
    expect_stall(3, "R6"); step();
    ys_v[1] = 0; raw_link(0, 0, 0, 3); expect_stall(2, "R6 slot0"); step();
    // R7: latency floor before double/inner/transform consumers
    clear_pair(); o_kind = 1; y_kind = 9; o_lat = 1; raw_link(0, 0, 1, 5);
    expect_stall(2, "R7"); step();
    od_f[0] = 0; ys_f[0] = 0; expect_stall(1, "R7 int dest"); step();
    // R8: RAW 3 together with WAR 5 on a vector transform
    clear_pair(); o_kind = 4; o_lat = 3; raw_link(0, 0, 1, 1);
    os_v[0] = 1; os_i[0] = 6; yd_v = 1; yd_i = 6;
    expect_stall(5, "R8 max"); step();
    // R8: tie RAW 2 vs WAR 2 reports RAW
    o_kind = 3; o_lat = 2; @(negedge clk);
    chk(hazard == 2'd1, "R8 tie", int'(hazard), 1); step();
    // R9 / R10: load a stall, offer new pairs while holding, then reset mid-count
    issue_valid = 1; o_lat = 6; step();
    repeat (3) step();
    rst = 1; step(); rst = 0;
    repeat (8) step();

    // Random pairs over a small register range
    for (int n = 0; n < 3000; n++) begin
      issue_valid = $urandom_range(0, 1);
      o_grp = $urandom_range(0, 1); y_grp = $urandom_range(0, 1);
      o_kind = 4'($urandom_range(0, 9)); y_kind = 4'($urandom_range(0, 9));
      o_lat = LW'($urandom); o_latl = LW'($urandom);
      for (int k = 0; k < 2; k++) begin
        od_v[k] = $urandom_range(0, 1); od_f[k] = $urandom_range(0, 1); od_i[k] = RW'($urandom_range(0, 3));
        os_v[k] = $urandom_range(0, 1); os_f[k] = $urandom_range(0, 1); os_i[k] = RW'($urandom_range(0, 3));
        ys_v[k] = $urandom_range(0, 1); ys_f[k] = $urandom_range(0, 1); ys_i[k] = RW'($urandom_range(0, 3));
      end
      yd_v = $urandom_range(0, 1); yd_f = $urandom_range(0, 1); yd_i = RW'($urandom_range(0, 3));
      rst = ($urandom_range(0, 199) == 0);
      step();
    end
    rst = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule